// File: doc/BRIEF.md
# DMA Operand Address and Byte-Count Sequencer

This block keeps the working state of one DMA channel. It holds a source pointer, a destination pointer, a remaining-byte counter and an 8-bit bus-qualifier register. A host loads these through a small register write port and reads them back through a read port. After a start strobe, the block sizes every operand as 1, 2 or 4 bytes and presents it to the bus engine. The size depends on each side's port width, the alignment of each pointer and the bytes still owed.

Each operand-complete strobe from the bus engine advances the source pointer by the operand size. It advances the destination pointer by the same amount, unless the destination is pinned to a fixed address. It also subtracts the size from the counter. The bus engine selects the read or write phase. The block then drives the matching pointer as the address, and the matching half of the qualifier register on a 4-bit code output.

The operand interface follows valid/ready in spirit. The size and address are valid while `active` is high. `op_done` is the acceptance: holding it low is the only back-pressure, and the state does not move while it is low. A count of zero at start means a full 2^32-byte run.

Top module: `dma_seq`

## Requirements
- R1: After reset, both pointers, the counter and the qualifier register read 0; `active`, `done` and `cfg_err` are 0.
- R2: A write (`wr_sel` 0 = source pointer, 1 = destination pointer, 2 = counter, 3 = qualifier in bits 7:0) updates the register only while `active` is low. While active, a write leaves every register unchanged. `rd_data` returns the current value of the register named by `rd_sel`, using the same encoding.
- R3: While active, `op_size` (binary 1, 2 or 4) equals the smaller of the source and destination sizes. Each side's size is the largest of 4, 2, 1 that meets three limits: it does not exceed the port width (`*_port_sz` 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes), the pointer is a multiple of it, and it does not exceed the remaining count.
- R4: Each accepted `op_done` adds `op_size` to the source pointer, modulo 2^32, with no error indication.
- R5: Each accepted `op_done` adds `op_size` to the destination pointer when `dst_hold` is 0, and leaves it unchanged when `dst_hold` is 1.
- R6: Each accepted `op_done` subtracts `op_size` from the counter. When the counter reaches 0, `done` is high for exactly one cycle and `active` falls in the same cycle.
- R7: A start with the counter at 0 runs 2^32 bytes. The first operand wraps the counter (0 − size) and raises no `done`.
- R8: With `phase_wr` = 0, `addr_o` is the source pointer and `fc_o` is qualifier bits 3:0. With `phase_wr` = 1, `addr_o` is the destination pointer and `fc_o` is qualifier bits 7:4.
- R9: Writing 0x77 to the qualifier register sets `cfg_err`, and writing any other qualifier value clears it. A start is ignored while `cfg_err` is 1.
- R10: `op_done` while idle changes no register and raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Current value of the selected register |
| src_port_sz | input | 2 | Source port width code |
| dst_port_sz | input | 2 | Destination port width code |
| dst_hold | input | 1 | Keep the destination pointer fixed |
| start | input | 1 | Start strobe |
| op_done | input | 1 | Operand completed strobe |
| phase_wr | input | 1 | 0 = read phase, 1 = write phase |
| op_size | output | 3 | Bytes in the current operand |
| addr_o | output | 32 | Bus address for the current phase |
| fc_o | output | 4 | Bus qualifier code for the current phase |
| active | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Forbidden qualifier value written |

## Verification
The hardest case to reach is a run where the source and destination start on different alignments and the count tail cuts across both. In that case the operand size changes several times within one run, for example 1, 2, 4, then 2 and 1 at the end. The stimulus sweeps every pairing of port widths with every byte offset of both pointers, every short count and both destination modes. A bench model recomputes each operand size and the final pointers and counter. The 2^32 case is reached by starting from a zero count with the source pointer just below the top of the address space, so that one operand also shows the pointer wrapping.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CNT = 2'd2,
    SEL_QUAL = 2'd3
  } reg_sel_e;

  localparam logic [7:0] QUAL_FORBIDDEN = 8'h77;

  function automatic logic [2:0] min_sz(input logic [2:0] a, input logic [2:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/dma_size_pick.sv
module dma_size_pick #(
  parameter int AW = 32
) (
  input  logic [1:0]    port_sz,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] rem,
  input  logic          rem_big,
  output logic [2:0]    sz
);
  import dma_seq_pkg::*;

  logic [2:0] cap_port, cap_align, cap_rem;

  always_comb begin
    unique case (port_sz)
      2'd0:    cap_port = 3'd1;
      2'd1:    cap_port = 3'd2;
      default: cap_port = 3'd4;
    endcase
    if (addr[0])      cap_align = 3'd1;
    else if (addr[1]) cap_align = 3'd2;
    else              cap_align = 3'd4;
    if (rem_big || rem >= AW'(4)) cap_rem = 3'd4;
    else if (rem >= AW'(2))       cap_rem = 3'd2;
    else                          cap_rem = 3'd1;
    sz = min_sz(min_sz(cap_port, cap_align), cap_rem);
  end
endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          hold,
  input  logic [2:0]    step,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)             q <= '0;
    else if (load)          q <= load_val;
    else if (adv && !hold)  q <= q + AW'(step);
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int AW  = 32,
  parameter int QW  = 8,
  localparam int FW = QW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic [1:0]    src_port_sz,
  input  logic [1:0]    dst_port_sz,
  input  logic          dst_hold,
  input  logic          start,
  input  logic          op_done,
  input  logic          phase_wr,
  output logic [2:0]    op_size,
  output logic [AW-1:0] addr_o,
  output logic [FW-1:0] fc_o,
  output logic          active,
  output logic          done,
  output logic          cfg_err
);
  import dma_seq_pkg::*;

  logic [AW-1:0] src_q, dst_q, cnt_q, cnt_next;
  logic [QW-1:0] qual_q;
  logic          active_q, big_q, done_q, err_q;
  logic [2:0]    sz_src, sz_dst, step;
  logic          host_ok, adv;

  assign host_ok = wr_en && !active_q;
  assign adv     = active_q && op_done;

  dma_size_pick #(.AW(AW)) u_pick_src (
    .port_sz(src_port_sz), .addr(src_q), .rem(cnt_q), .rem_big(big_q), .sz(sz_src));
  dma_size_pick #(.AW(AW)) u_pick_dst (
    .port_sz(dst_port_sz), .addr(dst_q), .rem(cnt_q), .rem_big(big_q), .sz(sz_dst));

  assign step     = min_sz(sz_src, sz_dst);
  assign cnt_next = cnt_q - AW'(step);

  dma_ptr #(.AW(AW)) u_src_ptr (
    .clk(clk), .rst_n(rst_n), .load(host_ok && wr_sel == SEL_SRC), .load_val(wr_data),
    .adv(adv), .hold(1'b0), .step(step), .q(src_q));
  dma_ptr #(.AW(AW)) u_dst_ptr (
    .clk(clk), .rst_n(rst_n), .load(host_ok && wr_sel == SEL_DST), .load_val(wr_data),
    .adv(adv), .hold(dst_hold), .step(step), .q(dst_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      qual_q   <= '0;
      active_q <= 1'b0;
      big_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (host_ok && wr_sel == SEL_CNT) cnt_q <= wr_data;
      if (host_ok && wr_sel == SEL_QUAL) begin
        qual_q <= wr_data[QW-1:0];
        err_q  <= (wr_data[QW-1:0] == QW'(QUAL_FORBIDDEN));
      end
      if (start && !active_q && !err_q) begin
        active_q <= 1'b1;
        big_q    <= (cnt_q == '0);
      end
      if (adv) begin
        cnt_q <= cnt_next;
        big_q <= 1'b0;
        if (cnt_next == '0) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_SRC:  rd_data = src_q;
      SEL_DST:  rd_data = dst_q;
      SEL_CNT:  rd_data = cnt_q;
      default:  rd_data = AW'(qual_q);
    endcase
  end

  assign addr_o  = phase_wr ? dst_q : src_q;
  assign fc_o    = phase_wr ? qual_q[QW-1:FW] : qual_q[FW-1:0];
  assign op_size = step;
  assign active  = active_q;
  assign done    = done_q;
  assign cfg_err = err_q;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          done,
  input logic          op_done,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [AW-1:0] wr_data,
  input logic          cfg_err,
  input logic [2:0]    op_size,
  input logic [AW-1:0] src_q,
  input logic [AW-1:0] cnt_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active); // R6
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(op_size) == 1)); // R3
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op_done) |=> (src_q == $past(src_q) + AW'($past(op_size)))); // R4
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !op_done && wr_en) |=> ($stable(cnt_q) && $stable(src_q))); // R2
  AST_IDLE_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !wr_en) |=> ($stable(src_q) && $stable(cnt_q))); // R10
  AST_BAD_QUAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !active && wr_sel == 2'd3 && wr_data[7:0] == 8'h77) |=> cfg_err); // R9
endmodule

bind dma_seq dma_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .done(done), .op_done(op_done),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cfg_err(cfg_err),
  .op_size(op_size), .src_q(src_q), .cnt_q(cnt_q));

// File: tb/dma_seq_bench.sv
`timescale 1ns/1ps
module dma_seq_bench;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, dst_hold = 0, start = 0, op_done = 0, phase_wr = 0;
  logic [1:0]  wr_sel = 0, rd_sel = 0, src_port_sz = 0, dst_port_sz = 0;
  logic [31:0] wr_data = 0, rd_data, addr_o;
  logic [2:0]  op_size;
  logic [3:0]  fc_o;
  logic        active, done, cfg_err;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  dma_seq u_dma_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .src_port_sz(src_port_sz),
    .dst_port_sz(dst_port_sz), .dst_hold(dst_hold), .start(start), .op_done(op_done),
    .phase_wr(phase_wr), .op_size(op_size), .addr_o(addr_o), .fc_o(fc_o),
    .active(active), .done(done), .cfg_err(cfg_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
    rd_sel = sel; #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic kick();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  function automatic logic [2:0] pick(input logic [1:0] p, input logic [31:0] a,
                                      input logic [32:0] rem);
    logic [2:0] m;
    m = (p == 0) ? 3'd1 : (p == 1) ? 3'd2 : 3'd4;
    if (a[0]) m = 3'd1;
    else if (a[1] && m > 2) m = 3'd2;
    if (rem < 33'(m)) m = (rem >= 2) ? 3'd2 : 3'd1;
    return m;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 src", 2'd0, 0); rd_chk("R1 dst", 2'd1, 0);
    rd_chk("R1 cnt", 2'd2, 0); rd_chk("R1 qual", 2'd3, 0);
    chk("R1 flags", {active, done, cfg_err}, 0);

    // R10 strobe while idle
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0;
    rd_chk("R10 src", 2'd0, 0); rd_chk("R10 cnt", 2'd2, 0);
    chk("R10 done", done, 0);

    // R8 phase muxing
    host_wr(2'd0, 32'h0000_1234); host_wr(2'd1, 32'h0000_5678); host_wr(2'd3, 32'hA5);
    phase_wr = 0; #0.5;
    chk("R8 rd addr", addr_o, 32'h1234); chk("R8 rd code", fc_o, 4'h5);
    phase_wr = 1; #0.5;
    chk("R8 wr addr", addr_o, 32'h5678); chk("R8 wr code", fc_o, 4'hA);
    phase_wr = 0;

    // R9 forbidden qualifier
    host_wr(2'd3, 32'h77);
    chk("R9 flag set", cfg_err, 1);
    host_wr(2'd2, 32'd8);
    kick();
    chk("R9 start blocked", active, 0);
    host_wr(2'd3, 32'h12);
    chk("R9 flag cleared", cfg_err, 0);

    // R7 full-range run, with source wrap (R4) and busy write (R2)
    host_wr(2'd0, 32'hFFFF_FFFC); host_wr(2'd1, 32'h10); host_wr(2'd2, 32'd0);
    src_port_sz = 2; dst_port_sz = 2; dst_hold = 1;
    kick();
    chk("R7 active", active, 1);
    chk("R7 size", op_size, 3'd4);
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0;
    chk("R7 no done", done, 0);
    chk("R7 still active", active, 1);
    rd_chk("R7 count wrap", 2'd2, 32'hFFFF_FFFC);
    rd_chk("R4 src wrap", 2'd0, 32'h0);
    rd_chk("R5 dst held", 2'd1, 32'h10);
    host_wr(2'd0, 32'h55);
    rd_chk("R2 busy write ignored", 2'd0, 32'h0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 reset mid-run", active, 0);

    // Sweep: R3 R4 R5 R6 R2
    for (int sp = 0; sp < 3; sp++)
      for (int dp = 0; dp < 3; dp++)
        for (int so = 0; so < 4; so++)
          for (int dof = 0; dof < 4; dof++)
            for (int hd = 0; hd < 2; hd++)
              for (int n = 1; n <= 9; n++) begin
                logic [31:0] es, ed, ec;
                logic [2:0] m;
                es = 32'h100 + 32'(so); ed = 32'h200 + 32'(dof); ec = 32'(n);
                host_wr(2'd0, es); host_wr(2'd1, ed); host_wr(2'd2, ec);
                rd_chk("R2 count load", 2'd2, ec);
                src_port_sz = 2'(sp); dst_port_sz = 2'(dp); dst_hold = hd[0];
                kick();
                while (ec != 0) begin
                  m = pick(2'(sp), es, {1'b0, ec});
                  if (pick(2'(dp), ed, {1'b0, ec}) < m) m = pick(2'(dp), ed, {1'b0, ec});
                  @(negedge clk);
                  chk("R3 operand size", op_size, m);
                  op_done = 1;
                  @(negedge clk); op_done = 0;
                  es = es + 32'(m); ec = ec - 32'(m);
                  if (hd == 0) ed = ed + 32'(m);
                  if (ec != 0) chk("R6 no early done", done, 0);
                end
                chk("R6 done pulse", done, 1);
                chk("R6 idle after", active, 0);
                rd_chk("R4 source end", 2'd0, es);
                rd_chk("R5 dest end", 2'd1, ed);
                rd_chk("R6 count end", 2'd2, 0);
                @(negedge clk);
                chk("R6 done one cycle", done, 0);
              end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule